// File: doc/BRIEF.md
# LIN Transceiver Mode and Wake Controller

This block is the digital control for two LIN transceiver channels. On every clock it works out an operating mode for each channel from a 2-bit system mode code, that channel's standby bit and a battery-good flag. Only an Active channel passes transmit data to its bus driver and bus data to its receive output. A channel in Lowpower mode watches its bus for a remote wake-up, and a channel that is Off does nothing.

Two timers share a free-running tick input. The wake filter accepts a wake-up only after the bus has stayed dominant for a set number of ticks. The transmit guard stops driving the bus when the transmit input has been held low for too many ticks. After it cuts in, the driver stays recessive until the transmit input returns high. Each channel's resolved mode is an output, so that the analog front end can be powered to match. A wake-up sets a flag that stays set until a clear pulse arrives.

The block has three states per channel. The mode register holds OFF, LOWPWR, ACTIVE or HOLD. The transmit guard holds TX_REC, TX_DOM or TX_LOCK. The wake filter holds WK_OFF, WK_REC, WK_DOM or WK_HIT. The transmit guard moves as follows: TX_REC→TX_DOM when the transmit input goes low; TX_DOM→TX_REC when it goes high; TX_DOM→TX_LOCK when the time-out count is reached; TX_LOCK→TX_REC when the input goes high. Leaving Active sends it to TX_REC. The wake filter moves as follows: WK_OFF or WK_REC→WK_DOM on a dominant sample; WK_DOM→WK_REC on a recessive sample; WK_DOM→WK_HIT when the wake count is reached; WK_HIT→WK_REC on a recessive sample. Leaving Lowpower sends it to WK_OFF.

Top module: `lin_xcvr_ctrl`

## Requirements
- R1: A channel whose standby bit is 1 enters LOWPWR (mode output 01) one clock later, whatever the system mode code and battery flag are.
- R2: With standby 0, a system mode code of 10 or 11 and battery-good 1, the channel enters ACTIVE (mode output 10) one clock later.
- R3: With standby 0 and a system mode code of 00 or 01, the channel is OFF (mode output 00). An OFF channel never drives dominant and never sets its wake flag. After reset every channel is OFF, with the driver recessive, the receive output high and the wake flag clear.
- R4: With standby 0, a system mode code of 10 or 11 and battery-good 0, the channel is in HOLD (mode output 11). In HOLD the driver stays recessive and the receive output stays high.
- R5: In ACTIVE the receive output equals the bus level (1 = recessive, 0 = dominant). The driver output is 1 (dominant) in the same cycle as the transmit input is 0, unless the channel is locked out. In every mode other than ACTIVE the receive output is 1 and the driver output is 0.
- R6: In ACTIVE, once TO_TICKS ticks have been counted while the transmit input stays low, the driver output goes to 0 even though the input is still low.
- R7: After a time-out the driver output stays 0 until the transmit input is sampled high. A later low level on the input then drives dominant again.
- R8: In LOWPWR the wake flag sets once WAKE_TICKS ticks have been counted while the bus stays dominant. Any recessive sample resets the count.
- R9: The wake flag stays set until a clear pulse arrives. If a set and a clear fall in the same cycle, the set wins.
- R10: The two channels are independent. Each has its own mode, time-out, lock-out and wake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Free-running timebase strobe, one clock wide |
| sys_mode | input | 2 | System mode code (00/01 standby or sleep, 10/11 normal) |
| bat_ok | input | 1 | Battery above the undervoltage recovery level |
| stby | input | N_CH | Per-channel standby bit |
| txd | input | N_CH | Per-channel transmit data (1 = recessive) |
| bus_rx | input | N_CH | Per-channel sampled bus level (1 = recessive) |
| wake_clr | input | N_CH | Per-channel clear of the wake flag |
| drv_dom | output | N_CH | Per-channel bus driver command (1 = dominant) |
| rxd | output | N_CH | Per-channel receive data (1 = recessive) |
| wake | output | N_CH | Per-channel sticky wake flag |
| xcvr_mode | output | 2*N_CH | Per-channel mode, 2 bits each, channel 0 in the low bits |

## Verification
The hardest cases to reach from the ports are timing coincidences. One is a wake-up being set in the very cycle a clear arrives. Another is a time-out landing on the exact tick that ends the count. The tick arrives on a fixed stride that is not aligned to the stimulus, so the stimulus sweeps the phases. The stimulus also holds the clear input high across a whole dominant interval, which forces the set and the clear to coincide. A cycle-accurate behavioural model is compared on every clock, so each such corner is checked on the cycle where it happens.

// File: rtl/lin_ctrl_pkg.sv
package lin_ctrl_pkg;

    typedef enum logic [1:0] {
        CM_OFF    = 2'b00,
        CM_LOWPWR = 2'b01,
        CM_ACTIVE = 2'b10,
        CM_HOLD   = 2'b11
    } chan_mode_e;

    typedef enum logic [1:0] {
        TX_REC  = 2'b00,
        TX_DOM  = 2'b01,
        TX_LOCK = 2'b10
    } tx_state_e;

    typedef enum logic [1:0] {
        WK_OFF = 2'b00,
        WK_REC = 2'b01,
        WK_DOM = 2'b10,
        WK_HIT = 2'b11
    } wk_state_e;

endpackage

// File: rtl/lin_mode_sel.sv
module lin_mode_sel
    import lin_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sys_mode_i,
    input  logic       stby_i,
    input  logic       bat_ok_i,
    output chan_mode_e mode_q
);

    chan_mode_e mode_d;

    // next-state decode
    always_comb begin
        if (stby_i) begin
            mode_d = CM_LOWPWR;
        end else begin
            unique case (sys_mode_i)
                2'b10, 2'b11: mode_d = bat_ok_i ? CM_ACTIVE : CM_HOLD;
                default:      mode_d = CM_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= CM_OFF;
        else        mode_q <= mode_d;
    end

    AST_MODE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        stby_i |=> (mode_q == CM_LOWPWR)); // R1
    AST_MODE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_mode_i[1] && !stby_i && bat_ok_i) |=> (mode_q == CM_ACTIVE)); // R2
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_mode_i[1] && !stby_i) |=> (mode_q == CM_OFF)); // R3

endmodule

// File: rtl/lin_tx_guard.sv
module lin_tx_guard
    import lin_ctrl_pkg::*;
#(
    parameter int TO_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic active_i,
    input  logic txd_i,
    output logic drv_dom_o
);

    localparam int CW = (TO_TICKS > 1) ? $clog2(TO_TICKS) : 1;
    localparam logic [CW-1:0] TO_LAST = CW'(TO_TICKS - 1);

    tx_state_e       st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!active_i) begin
            st_d  = TX_REC;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                TX_REC: begin
                    if (!txd_i) begin
                        st_d  = TX_DOM;
                        cnt_d = '0;
                    end
                end
                TX_DOM: begin
                    if (txd_i) begin
                        st_d = TX_REC;
                    end else if (tick_i) begin
                        if (cnt_q == TO_LAST) st_d  = TX_LOCK;
                        else                  cnt_d = cnt_q + 1'b1;
                    end
                end
                TX_LOCK: begin
                    if (txd_i) st_d = TX_REC;
                end
                default: st_d = TX_REC;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= TX_REC;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        drv_dom_o = active_i && !txd_i && (st_q != TX_LOCK);
    end

    AST_TO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_DOM) |-> (cnt_q <= TO_LAST)); // R6
    AST_TIMEOUT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_DOM && active_i && !txd_i && tick_i && cnt_q == TO_LAST)
        |=> !drv_dom_o); // R6
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_LOCK && active_i && !txd_i) |=> (st_q == TX_LOCK)); // R7

endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter
    import lin_ctrl_pkg::*;
#(
    parameter int WAKE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic lowpwr_i,
    input  logic bus_i,
    input  logic clr_i,
    output logic wake_o
);

    localparam int CW = (WAKE_TICKS > 1) ? $clog2(WAKE_TICKS) : 1;
    localparam logic [CW-1:0] WK_LAST = CW'(WAKE_TICKS - 1);

    wk_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit;
    logic          wake_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (!lowpwr_i) begin
            st_d  = WK_OFF;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                WK_OFF, WK_REC: begin
                    if (!bus_i) begin
                        st_d  = WK_DOM;
                        cnt_d = '0;
                    end else begin
                        st_d = WK_REC;
                    end
                end
                WK_DOM: begin
                    if (bus_i) begin
                        st_d = WK_REC;
                    end else if (tick_i) begin
                        if (cnt_q == WK_LAST) begin
                            st_d = WK_HIT;
                            hit  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                WK_HIT: begin
                    if (bus_i) st_d = WK_REC;
                end
                default: st_d = WK_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= WK_OFF;
            cnt_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (hit)        wake_q <= 1'b1;
            else if (clr_i) wake_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        wake_o = wake_q;
    end

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !clr_i) |=> wake_o); // R9
    AST_WAKE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && bus_i) |=> !wake_o); // R9
    AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(lowpwr_i && !bus_i)); // R8
    AST_WK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WK_DOM) |-> (cnt_q <= WK_LAST)); // R8

endmodule

// File: rtl/lin_xcvr_ctrl.sv
module lin_xcvr_ctrl
    import lin_ctrl_pkg::*;
#(
    parameter int N_CH       = 2,
    parameter int TO_TICKS   = 8,
    parameter int WAKE_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        sys_mode,
    input  logic              bat_ok,
    input  logic [N_CH-1:0]   stby,
    input  logic [N_CH-1:0]   txd,
    input  logic [N_CH-1:0]   bus_rx,
    input  logic [N_CH-1:0]   wake_clr,
    output logic [N_CH-1:0]   drv_dom,
    output logic [N_CH-1:0]   rxd,
    output logic [N_CH-1:0]   wake,
    output logic [2*N_CH-1:0] xcvr_mode
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        chan_mode_e mode;
        logic       is_active;
        logic       is_lowpwr;

        lin_mode_sel u_mode (
            .clk        (clk),
            .rst_n      (rst_n),
            .sys_mode_i (sys_mode),
            .stby_i     (stby[c]),
            .bat_ok_i   (bat_ok),
            .mode_q     (mode)
        );

        always_comb begin
            is_active = (mode == CM_ACTIVE);
            is_lowpwr = (mode == CM_LOWPWR);
            rxd[c]    = is_active ? bus_rx[c] : 1'b1;
            xcvr_mode[2*c +: 2] = mode;
        end

        lin_tx_guard #(.TO_TICKS(TO_TICKS)) u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick),
            .active_i  (is_active),
            .txd_i     (txd[c]),
            .drv_dom_o (drv_dom[c])
        );

        lin_wake_filter #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .lowpwr_i (is_lowpwr),
            .bus_i    (bus_rx[c]),
            .clr_i    (wake_clr[c]),
            .wake_o   (wake[c])
        );

        AST_DRV_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            drv_dom[c] |-> (xcvr_mode[2*c +: 2] == 2'b10)); // R5
        AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (xcvr_mode[2*c +: 2] == 2'b11) |-> (!drv_dom[c] && rxd[c])); // R4
    end

endmodule

// File: tb/sim_lin_xcvr_ctrl.sv
module sim_lin_xcvr_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NC   = 2;
    localparam int TO   = 8;
    localparam int WK   = 4;
    localparam int TSTR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [1:0]    sys_mode = 2'b00;
    logic          bat_ok = 1'b1;
    logic [NC-1:0] stby = '0;
    logic [NC-1:0] txd = '1;
    logic [NC-1:0] bus_rx = '1;
    logic [NC-1:0] wake_clr = '0;
    logic [NC-1:0] drv_dom, rxd, wake;
    logic [2*NC-1:0] xcvr_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_xcvr_ctrl #(.N_CH(NC), .TO_TICKS(TO), .WAKE_TICKS(WK)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sys_mode(sys_mode),
        .bat_ok(bat_ok), .stby(stby), .txd(txd), .bus_rx(bus_rx),
        .wake_clr(wake_clr), .drv_dom(drv_dom), .rxd(rxd), .wake(wake),
        .xcvr_mode(xcvr_mode)
    );

    // tick strobe: one clock in every TSTR
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph  = (ph + 1) % TSTR;
            tick = (ph == 0);
        end
    end

    // behavioural reference (modes: 0 off, 1 lowpower, 2 active, 3 hold)
    int m_mode [NC];
    int m_txs  [NC];   // 0 idle, 1 low and counting, 2 locked out
    int m_tcnt [NC];
    int m_ws   [NC];   // 0 off, 1 recessive, 2 dominant counting, 3 accepted
    int m_wcnt [NC];
    int m_wake [NC];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) begin
                m_mode[c] = 0; m_txs[c] = 0; m_tcnt[c] = 0;
                m_ws[c] = 0; m_wcnt[c] = 0; m_wake[c] = 0;
            end
        end else begin
            for (int c = 0; c < NC; c++) begin
                int nm;
                bit set;
                set = 0;
                if (stby[c])          nm = 1;
                else if (sys_mode[1]) nm = bat_ok ? 2 : 3;
                else                  nm = 0;
                if (m_mode[c] != 2) begin
                    m_txs[c] = 0; m_tcnt[c] = 0;
                end else if (m_txs[c] == 0) begin
                    if (!txd[c]) begin m_txs[c] = 1; m_tcnt[c] = 0; end
                end else if (m_txs[c] == 1) begin
                    if (txd[c]) m_txs[c] = 0;
                    else if (tick) begin
                        m_tcnt[c]++;
                        if (m_tcnt[c] == TO) m_txs[c] = 2;
                    end
                end else begin
                    if (txd[c]) m_txs[c] = 0;
                end
                if (m_mode[c] != 1) begin
                    m_ws[c] = 0; m_wcnt[c] = 0;
                end else if (m_ws[c] <= 1) begin
                    if (!bus_rx[c]) begin m_ws[c] = 2; m_wcnt[c] = 0; end
                    else m_ws[c] = 1;
                end else if (m_ws[c] == 2) begin
                    if (bus_rx[c]) m_ws[c] = 1;
                    else if (tick) begin
                        m_wcnt[c]++;
                        if (m_wcnt[c] == WK) begin m_ws[c] = 3; set = 1; end
                    end
                end else begin
                    if (bus_rx[c]) m_ws[c] = 1;
                end
                if (set)              m_wake[c] = 1;
                else if (wake_clr[c]) m_wake[c] = 0;
                m_mode[c] = nm;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NC; c++) begin
                int ed, er;
                ed = (m_mode[c] == 2 && !txd[c] && m_txs[c] != 2) ? 1 : 0;
                er = (m_mode[c] == 2) ? int'(bus_rx[c]) : 1;
                chk("R1/R2", "mode", int'(xcvr_mode[2*c +: 2]), m_mode[c]);
                chk("R5", "drv_dom", int'(drv_dom[c]), ed);
                chk("R5", "rxd", int'(rxd[c]), er);
                chk("R8", "wake", int'(wake[c]), m_wake[c]);
            end
        end
    end

    task automatic go(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look;
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        go(3);
        rst_n = 1'b1;
        go(2);
        look;
        // R3 reset state
        chk("R3", "reset mode", int'(xcvr_mode), 0);
        chk("R3", "reset rxd", int'(rxd), 3);
        chk("R3", "reset drv", int'(drv_dom), 0);
        chk("R3", "reset wake", int'(wake), 0);

        // R2 active, R5 pass-through
        go(1); sys_mode = 2'b10;
        go(2); look;
        chk("R2", "ch0 active", int'(xcvr_mode[1:0]), 2);
        go(1); txd = 2'b10; bus_rx = 2'b10;
        look;
        chk("R5", "ch0 drive", int'(drv_dom), 1);
        chk("R5", "rxd follow", int'(rxd), 2);
        for (int i = 0; i < 12; i++) begin
            go(1); txd = 2'(i); bus_rx = 2'(i + 1);
        end
        go(1); sys_mode = 2'b11; txd = '1; bus_rx = '1;

        // R6 time-out on ch0 while ch1 keeps toggling (R10)
        go(1); txd[0] = 1'b0;
        for (int i = 0; i < 40; i++) begin
            go(1); txd[1] = i[1];
        end
        look;
        chk("R6", "ch0 cut", int'(drv_dom[0]), 0);
        go(1); txd[1] = 1'b0;
        look;
        chk("R10", "ch1 still drives", int'(drv_dom[1]), 1);
        // R7 release then resume
        go(1); txd = 2'b11;
        go(2); txd[0] = 1'b0;
        look;
        chk("R7", "ch0 resumes", int'(drv_dom[0]), 1);
        go(1); txd = '1;

        // R4 hold on low battery
        go(1); bat_ok = 1'b0; txd = 2'b00; bus_rx = 2'b00;
        go(3); look;
        chk("R4", "hold mode", int'(xcvr_mode), 4'b1111);
        chk("R4", "hold drv", int'(drv_dom), 0);
        chk("R4", "hold rxd", int'(rxd), 3);

        // R3 off: dominant bus ignored
        go(1); bat_ok = 1'b1; sys_mode = 2'b01; txd = '1;
        go(30); look;
        chk("R3", "off mode", int'(xcvr_mode), 0);
        chk("R3", "off no wake", int'(wake), 0);

        // R8 lowpower on ch0 only, short pulse rejected
        go(1); stby = 2'b01; bus_rx = '1;
        go(3); look;
        chk("R1", "ch0 lowpwr", int'(xcvr_mode[1:0]), 1);
        go(1); bus_rx = 2'b10;
        go(5); bus_rx = 2'b11;
        go(3); look;
        chk("R8", "short pulse", int'(wake[0]), 0);
        go(1); bus_rx = 2'b00;
        go(30); look;
        chk("R8", "ch0 wake", int'(wake[0]), 1);
        chk("R10", "ch1 no wake", int'(wake[1]), 0);

        // R9 sticky then clear
        go(1); bus_rx = '1;
        go(10); look;
        chk("R9", "sticky", int'(wake[0]), 1);
        go(1); wake_clr = 2'b01;
        go(1); wake_clr = '0;
        look;
        chk("R9", "cleared", int'(wake[0]), 0);

        // R1 both channels lowpower under normal mode; clear held through a wake
        go(1); stby = 2'b11; sys_mode = 2'b10; wake_clr = 2'b11;
        go(3); look;
        chk("R1", "both lowpwr", int'(xcvr_mode), 4'b0101);
        for (int i = 0; i < 3; i++) begin
            go(1); bus_rx = 2'b00;
            go(20 + i); bus_rx = 2'b11;
        end
        go(1); wake_clr = '0; bus_rx = 2'b01;
        go(25); look;
        chk("R9", "ch1 wake kept", int'(wake[1]), 1);
        go(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule